// File: doc/BRIEF.md
# Incoming Field Length Meter

This block measures how long each incoming video field lasts. It does not watch the vertical sync input on every clock. A divider on the acquisition clock produces a sampling strobe at a fixed period of about 32 microseconds, and software chooses where in that period the strobe falls. The sync input is looked at only when the strobe fires. The field length is the number of strobes from one sampled rising edge of sync to the next, held as a 10-bit count with an overflow flag.

Finished lengths go alternately into an odd-field slot and an even-field slot, and a flag records which slot was written last. Software reads each slot as two bytes through a small select port. The low byte holds the eight low bits of the count. The high byte holds the two upper count bits together with the overflow flag and the last-field flag. Software uses the two lengths to tell standards apart and to detect interlace; that decision is not made here.

Top module: `field_len_meter`

## Requirements
- R1: After a synchronous active-low reset both length slots and both overflow flags are 0, `last_even` is 1, and `rd_data` is 0 for select values 0 and 2 and 8'h80 for select values 1 and 3.
- R2: `sample_pulse` is high in exactly one cycle of every `cfg_period`+1 cycles. It is high in the cycle where the internal divider count equals `cfg_phase`, and the divider count is 0 in the first cycle after reset is released.
- R3: `vsync_in` is sampled only in cycles where `sample_pulse` is high. A high level that appears and goes away between strobes has no effect on the counts or slots.
- R4: A rising edge of sync happens when a strobe samples 1 and the previous strobe sampled 0. It stores the running count and restarts counting at 1 on that strobe. The stored length is the number of strobes from the previous rising edge up to, but not including, this one.
- R5: The count stops at 1023. A strobe without a rising edge that finds the count at 1023 sets the overflow flag of the field in progress. A field of exactly 1023 strobes is stored as 1023 with no overflow, and any longer field is stored as 1023 with overflow.
- R6: Stored lengths alternate between the slots. A store goes to the odd slot when `last_even` is 1 and to the even slot otherwise, and `last_even` inverts on every store. The slots and the flag change in the clock edge of the rising-edge strobe.
- R7: Read map for `rd_sel`: 0 gives the odd low byte, 1 the odd high byte, 2 the even low byte and 3 the even high byte. In a high byte, bit 7 is `last_even`, bit 6 is the slot's overflow flag, bits 5..2 are 0 and bits 1..0 are length bits 9..8.
- R8: The first rising edge after reset only starts counting and stores nothing.
- R9: Sync held high over several strobes counts as a single rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | DIV_W | Strobe period minus one, in clocks |
| cfg_phase | input | DIV_W | Divider count at which the strobe fires |
| vsync_in | input | 1 | Vertical sync, synchronous to clk |
| rd_sel | input | 2 | Byte select for the read port |
| sample_pulse | output | 1 | Sampling strobe |
| odd_len | output | LEN_W | Odd-slot field length |
| odd_ovf | output | 1 | Odd-slot overflow flag |
| even_len | output | LEN_W | Even-slot field length |
| even_ovf | output | 1 | Even-slot overflow flag |
| last_even | output | 1 | 1 when the even slot was written last |
| rd_data | output | 8 | Selected byte |

## Verification
The assertions check four things on every cycle:
- A strobe is never followed by another strobe one cycle later unless the period is zero or the configuration changed.
- The slots and the field flag change only right after a strobe that sampled sync high.
- The two slots never change in the same edge.
- An overflow flag never stands next to a length other than 1023.

Only the bench scenarios can show the rest: the exact strobe phase and spacing, the stored values for a sweep of field lengths, the saturation point around 1023, the rejection of glitches between strobes, the byte layout of the read port, and the arming behaviour after reset.

// File: rtl/flm_pkg.sv
// Package: shared constants and read-select encoding for the field length meter.
// Assumes an 8-bit read port with the field flag and overflow flag at fixed
// positions in the high byte.
package flm_pkg;

    localparam int RD_W        = 8;
    localparam int HI_FLAG_BIT = 7;
    localparam int HI_OVF_BIT  = 6;

    typedef enum logic [1:0] {
        SEL_ODD_LO  = 2'd0,
        SEL_ODD_HI  = 2'd1,
        SEL_EVEN_LO = 2'd2,
        SEL_EVEN_HI = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/flm_strobe_gen.sv
// Module: programmable sampling-strobe generator.
// A free-running divider counts 0..cfg_period and fires the strobe when it
// equals cfg_phase. Assumes cfg_phase <= cfg_period; otherwise no strobe fires.
module flm_strobe_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_period,
    input  logic [DIV_W-1:0] cfg_phase,
    output logic             strobe_o
);

    logic [DIV_W-1:0] div_cnt;

    // Divider: wrap to zero at (or beyond, after a reconfiguration) the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt >= cfg_period) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Strobe decode: one cycle per divider turn at the chosen phase.
    always_comb begin
        strobe_o = (div_cnt == cfg_phase);
    end

endmodule

// File: rtl/flm_field_counter.sv
// Module: sync edge detection and strobe counting.
// Samples vsync only on strobes, detects a 0->1 change between consecutive
// samples, and counts strobes between such edges with saturation at the
// maximum count. The first edge after reset arms the counter only.
// Assumes vsync_in is already synchronous to clk.
module flm_field_counter #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             vsync_i,
    output logic             cap_o,
    output logic [LEN_W-1:0] len_o,
    output logic             ovf_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic             vs_last;
    logic             armed;
    logic             rise;
    logic [LEN_W-1:0] cnt;
    logic             ovf;

    // Edge decode: new sample high, previous sample low, on a strobe.
    always_comb begin
        rise  = strobe_i && vsync_i && !vs_last;
        cap_o = rise && armed;
    end

    // Counter state: remember the sample, restart on edges, saturate at max.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_last <= 1'b0;
            armed   <= 1'b0;
            cnt     <= '0;
            ovf     <= 1'b0;
        end else if (strobe_i) begin
            vs_last <= vsync_i;
            if (rise) begin
                armed <= 1'b1;
                cnt   <= LEN_ONE;
                ovf   <= 1'b0;
            end else if (armed) begin
                if (cnt == LEN_MAX) begin
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign len_o = cnt;
    assign ovf_o = ovf;

endmodule

// File: rtl/flm_capture.sv
// Module: odd/even capture registers.
// On each capture request the presented length goes into the slot opposite to
// the one written last, and the field flag inverts. Reset points the flag at
// the even slot so that the first store lands in the odd slot.
module flm_capture #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ovf_i,
    output logic [LEN_W-1:0] odd_len_o,
    output logic             odd_ovf_o,
    output logic [LEN_W-1:0] even_len_o,
    output logic             even_ovf_o,
    output logic             last_even_o
);

    // Slot write: steer by the flag, then invert it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_len_o   <= '0;
            odd_ovf_o   <= 1'b0;
            even_len_o  <= '0;
            even_ovf_o  <= 1'b0;
            last_even_o <= 1'b1;
        end else if (cap_i) begin
            if (last_even_o) begin
                odd_len_o <= len_i;
                odd_ovf_o <= ovf_i;
            end else begin
                even_len_o <= len_i;
                even_ovf_o <= ovf_i;
            end
            last_even_o <= !last_even_o;
        end
    end

endmodule

// File: rtl/field_len_meter.sv
// Module: top of the incoming field length meter.
// Ties the strobe generator, the edge counter and the capture slots together
// and presents the slots as bytes on a select-driven read port.
// Assumes LEN_W is between 9 and 14 so that the upper bits fit the high byte.
module field_len_meter #(
    parameter int DIV_W = 12,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_period,
    input  logic [DIV_W-1:0] cfg_phase,
    input  logic             vsync_in,
    input  logic [1:0]       rd_sel,
    output logic             sample_pulse,
    output logic [LEN_W-1:0] odd_len,
    output logic             odd_ovf,
    output logic [LEN_W-1:0] even_len,
    output logic             even_ovf,
    output logic             last_even,
    output logic [7:0]       rd_data
);

    import flm_pkg::*;

    localparam int HI_W  = LEN_W - 8;
    localparam int PAD_W = HI_OVF_BIT - HI_W;

    logic             cap;
    logic [LEN_W-1:0] run_len;
    logic             run_ovf;

    flm_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .cfg_phase  (cfg_phase),
        .strobe_o   (sample_pulse)
    );

    flm_field_counter #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (sample_pulse),
        .vsync_i  (vsync_in),
        .cap_o    (cap),
        .len_o    (run_len),
        .ovf_o    (run_ovf)
    );

    flm_capture #(.LEN_W(LEN_W)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap),
        .len_i       (run_len),
        .ovf_i       (run_ovf),
        .odd_len_o   (odd_len),
        .odd_ovf_o   (odd_ovf),
        .even_len_o  (even_len),
        .even_ovf_o  (even_ovf),
        .last_even_o (last_even)
    );

    // Read mux: low bytes carry count bits 7..0, high bytes carry the flags and upper bits.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            SEL_ODD_LO:  rd_data = odd_len[7:0];
            SEL_ODD_HI:  rd_data = {last_even, odd_ovf, {PAD_W{1'b0}}, odd_len[LEN_W-1:8]};
            SEL_EVEN_LO: rd_data = even_len[7:0];
            default:     rd_data = {last_even, even_ovf, {PAD_W{1'b0}}, even_len[LEN_W-1:8]};
        endcase
    end

endmodule

// File: rtl/flm_checker.sv
// Module: cycle-level property checker for field_len_meter, attached by bind.
// Watches only the top-level ports.
module flm_checker #(
    parameter int DIV_W = 12,
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] cfg_period,
    input logic [DIV_W-1:0] cfg_phase,
    input logic             vsync_in,
    input logic             sample_pulse,
    input logic [LEN_W-1:0] odd_len,
    input logic             odd_ovf,
    input logic [LEN_W-1:0] even_len,
    input logic             even_ovf,
    input logic             last_even
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    AST_STROBE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse && (cfg_period != '0)) |=>
            (!sample_pulse || (cfg_period != $past(cfg_period)) || (cfg_phase != $past(cfg_phase)))); // R2

    AST_ODD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(odd_len) |-> $past(sample_pulse && vsync_in)); // R3

    AST_EVEN_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(even_len) |-> $past(sample_pulse && vsync_in)); // R3

    AST_ODD_OVF_AT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        odd_ovf |-> (odd_len == LEN_MAX)); // R5

    AST_EVEN_OVF_AT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        even_ovf |-> (even_len == LEN_MAX)); // R5

    AST_FLAG_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_even) |-> $past(sample_pulse && vsync_in)); // R6

    AST_ONE_SLOT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(odd_len) && !$stable(even_len))); // R6

endmodule

bind field_len_meter flm_checker #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_flm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_period   (cfg_period),
    .cfg_phase    (cfg_phase),
    .vsync_in     (vsync_in),
    .sample_pulse (sample_pulse),
    .odd_len      (odd_len),
    .odd_ovf      (odd_ovf),
    .even_len     (even_len),
    .even_ovf     (even_ovf),
    .last_even    (last_even)
);

// File: tb/field_len_meter_test.sv
// Bench: sweeps strobe configurations and field lengths, predicting every
// stored value arithmetically from the requirements.
module field_len_meter_test;

    localparam int DIV_W = 12;
    localparam int LEN_W = 10;
    localparam int MAXL  = 1023;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_period = '0;
    logic [DIV_W-1:0] cfg_phase = '0;
    logic             vsync_in = 1'b0;
    logic [1:0]       rd_sel = 2'd0;
    logic             sample_pulse;
    logic [LEN_W-1:0] odd_len;
    logic             odd_ovf;
    logic [LEN_W-1:0] even_len;
    logic             even_ovf;
    logic             last_even;
    logic [7:0]       rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int e_odd = 0, e_even = 0, e_odd_ovf = 0, e_even_ovf = 0, e_last = 1;

    always #10 clk = ~clk;

    field_len_meter #(.DIV_W(DIV_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_phase(cfg_phase),
        .vsync_in(vsync_in), .rd_sel(rd_sel), .sample_pulse(sample_pulse),
        .odd_len(odd_len), .odd_ovf(odd_ovf), .even_len(even_len), .even_ovf(even_ovf),
        .last_even(last_even), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Wait for n strobes; called between edges, returns between edges after the last one.
    task automatic wait_strobes(input int n);
        for (int i = 0; i < n; i++) begin
            while (!sample_pulse) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vsync_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_odd = 0; e_even = 0; e_odd_ovf = 0; e_even_ovf = 0; e_last = 1;
    endtask

    task automatic check_slots(input string req);
        chk(req, "odd_len", int'(odd_len), e_odd);
        chk(req, "odd_ovf", int'(odd_ovf), e_odd_ovf);
        chk(req, "even_len", int'(even_len), e_even);
        chk(req, "even_ovf", int'(even_ovf), e_even_ovf);
        chk(req, "last_even", int'(last_even), e_last);
    endtask

    // R7 byte layout: low = len[7:0]; high = {flag, ovf, 0000, len[9:8]}.
    task automatic check_read(input string req);
        for (int s = 0; s < 4; s++) begin
            int len;
            int ov;
            int exp;
            len = (s < 2) ? e_odd : e_even;
            ov  = (s < 2) ? e_odd_ovf : e_even_ovf;
            exp = (s % 2 == 0) ? (len % 256) : (e_last * 128 + ov * 64 + len / 256);
            rd_sel = 2'(s);
            #1;
            chk(req, $sformatf("rd_data sel %0d", s), int'(rd_data), exp);
        end
    endtask

    task automatic model_capture(input int n);
        int len;
        int ov;
        len = (n > MAXL) ? MAXL : n;
        ov  = (n > MAXL) ? 1 : 0;
        if (e_last == 1) begin e_odd = len; e_odd_ovf = ov; end
        else begin e_even = len; e_even_ovf = ov; end
        e_last = 1 - e_last;
    endtask

    // One field of n strobes: high for h strobes from the rise, then low, optional glitch.
    task automatic fld(input int n, input int h, input bit glitch, input string req);
        int used;
        used = 0;
        wait_strobes(h - 1);
        vsync_in = 1'b0;
        if (glitch) begin
            while (sample_pulse) begin
                @(negedge clk);
                used++;
            end
            vsync_in = 1'b1;
            @(negedge clk);
            vsync_in = 1'b0;
        end
        wait_strobes(n - h - used);
        vsync_in = 1'b1;
        wait_strobes(1);
        model_capture(n);
        check_slots(req);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int periods [5] = '{0, 3, 7, 7, 12};
        int phases  [5] = '{0, 2, 0, 7, 5};

        // R1 reset state
        do_reset();
        #1;
        check_slots("R1");
        check_read("R1");

        // R2 strobe phase and spacing sweep
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            rst_n = 1'b0;
            cfg_period = DIV_W'(periods[c]);
            cfg_phase  = DIV_W'(phases[c]);
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            begin
                int j;
                j = 0;
                #1;
                while (!sample_pulse && j < 5000) begin
                    @(negedge clk);
                    #1;
                    j++;
                end
                chk("R2", "first strobe cycle", j, phases[c]);
                for (int k = 0; k < 3; k++) begin
                    int gap;
                    gap = 0;
                    do begin
                        @(negedge clk);
                        #1;
                        gap++;
                    end while (!sample_pulse && gap < 5000);
                    chk("R2", "strobe spacing", gap, periods[c] + 1);
                end
            end
        end

        // Field sweep at a 4-clock strobe
        cfg_period = DIV_W'(3);
        cfg_phase  = DIV_W'(1);
        do_reset();
        vsync_in = 1'b1;
        wait_strobes(1);
        check_slots("R8");
        for (int n = 2; n <= 40; n++) begin
            int h;
            bit g;
            h = 1 + (n % 3);
            if (h >= n) h = n - 1;
            g = (n % 4 == 0);
            fld(n, h, g, g ? "R3/R4/R6" : (h > 1 ? "R4/R6/R9" : "R4/R6"));
            if (n % 10 == 0) check_read("R7");
        end

        // Saturation at a 2-clock strobe
        cfg_period = DIV_W'(1);
        cfg_phase  = DIV_W'(0);
        fld(5, 1, 1'b0, "R4");
        fld(1023, 1, 1'b0, "R5");
        fld(1024, 2, 1'b0, "R5");
        check_read("R5/R7");
        fld(1500, 1, 1'b0, "R5");
        fld(6, 1, 1'b0, "R5");
        check_read("R5/R7");

        // Reset again: slots clear, first edge arms only
        do_reset();
        #1;
        check_slots("R1");
        vsync_in = 1'b1;
        wait_strobes(1);
        check_slots("R8");
        fld(9, 3, 1'b1, "R8/R4");
        check_read("R7");

        summary();
    end

endmodule